// File: doc/BRIEF.md
# Two-Mode Beamforming Sequencer

This block is the control sequencer of a volumetric beamforming engine. For every ultrasound shot it walks a grid of steering directions and produces the read enables, bin addresses, channel indices and mode flags that a datapath of delay-and-sum beamformers, complex multipliers and accumulators needs. It does no arithmetic of its own.

A shot begins in acquisition mode. This mode covers only direction 0. It handles the channels one by one, as the front-end transform finishes each channel. A channel's 2048 time samples become 512 frequency bins. The channel index also addresses a small buffer that holds the delay word of each channel for the current direction. When the last channel is done, the sequencer switches to compute mode and turns the front-end transform off. In compute mode it handles the remaining directions from stored spectra. Each read cycle fetches a group of channels in parallel, and the partial sums of the group are added before they are accumulated. After the last direction, the sequencer waits in a reload state while the next shot's reference spectra are loaded. It then starts the next shot in acquisition mode.

Top module: `beam_seq_top`

## Requirements
- R1: After reset, mode is 0, fe_en is 1, rd_valid, beam_done and shot_done are 0, and dir_idx, chan_idx and bin_addr are 0.
- R2: In acquisition mode a channel starts only when echo_ready is sampled high while no channel is streaming. The channel then issues NUM_BINS reads on consecutive cycles with bin_addr 0 to NUM_BINS-1, whatever echo_ready does. After the last read the sequencer waits for echo_ready again.
- R3: In acquisition mode dir_idx is 0, and chan_idx takes the channel number (the delay-buffer address), in order 0 to NUM_CH-1.
- R4: The last read of channel NUM_CH-1 in acquisition mode switches the mode to compute (1) on the next cycle, with dir_idx 1 and fe_en 0.
- R5: In compute mode a read is issued every cycle. The sequencer steps through NUM_CH/PAR_CH groups, in order. chan_idx is the first channel of the group (group times PAR_CH), and bin_addr runs 0 to NUM_BINS-1 within each group.
- R6: beam_done is high only on the last read of a direction, for one cycle. On the next cycle dir_idx has gone up by one, unless the shot has ended.
- R7: shot_done is high for one cycle, on the last read of direction NUM_DIRS-1. The next cycle is in reload mode (2), with no reads.
- R8: Reload mode holds until reload_done is sampled high. The next cycle is in acquisition mode with dir_idx 0 and no channel streaming.
- R9: acc_first is high exactly on reads of channel 0 in acquisition mode and of group 0 in compute mode.
- R10: reload_done has no effect outside reload mode, and echo_ready has no effect outside acquisition mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| echo_ready | input | 1 | Transform output of the next channel is available |
| reload_done | input | 1 | Reference spectra for the next shot are loaded |
| mode | output | 2 | 0 acquisition, 1 compute, 2 reload |
| fe_en | output | 1 | Front-end transform enable |
| rd_valid | output | 1 | A spectrum read is issued this cycle |
| acc_first | output | 1 | Read belongs to the first channel or group of a direction |
| dir_idx | output | DIR_W | Steering direction index (12 bits by default) |
| chan_idx | output | CH_W | Channel (acquisition) or group base channel (compute) |
| bin_addr | output | BIN_W | Frequency bin address |
| beam_done | output | 1 | Last read of a direction |
| shot_done | output | 1 | Last read of the shot |

## Verification
The bench runs several whole shots against a cycle model of the requirements. echo_ready comes from a seeded random stream with frequent gaps, and a directed stretch holds it low at the start. This shows whether channels start only on the handshake and whether the stream of a channel ignores the input. reload_done is pulsed at random in every mode, which separates a correct reload wait from one that can be entered or left early. The same pulses test that inputs are ignored outside their own mode. The model compares every output on every cycle, so the order of the group and bin steps and the off-by-one boundaries at the ends of channels, directions and shots are all checked.

// File: rtl/beam_seq_pkg.sv
package beam_seq_pkg;
  typedef enum logic [1:0] {
    MODE_ACQ    = 2'd0,
    MODE_COMP   = 2'd1,
    MODE_RELOAD = 2'd2
  } seq_mode_e;
endpackage

// File: rtl/beam_seq_ctr.sv
module beam_seq_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] last_val,
  output logic [W-1:0] cnt,
  output logic         at_last
);
  assign at_last = (cnt == last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (inc)     cnt <= at_last ? '0 : cnt + W'(1);
  end
endmodule

// File: rtl/beam_seq_fsm.sv
module beam_seq_fsm
  import beam_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      echo_ready,
  input  logic      reload_done,
  input  logic      bin_last,
  input  logic      idx_last,
  input  logic      dir_last,
  output seq_mode_e mode,
  output logic      rd_valid,
  output logic      ch_done,
  output logic      beam_done,
  output logic      shot_done,
  output logic      dir_inc,
  output logic      dir_clr
);
  logic streaming;
  logic in_acq, in_comp, in_rel;

  assign in_acq    = (mode == MODE_ACQ);
  assign in_comp   = (mode == MODE_COMP);
  assign in_rel    = (mode == MODE_RELOAD);
  assign rd_valid  = (in_acq && streaming) || in_comp;
  assign ch_done   = rd_valid && bin_last;
  assign beam_done = ch_done && idx_last;
  assign shot_done = beam_done && in_comp && dir_last;
  assign dir_inc   = beam_done && !shot_done;
  assign dir_clr   = in_rel && reload_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= MODE_ACQ;
      streaming <= 1'b0;
    end else begin
      unique case (mode)
        MODE_ACQ: begin
          if (!streaming) begin
            if (echo_ready) streaming <= 1'b1;
          end else if (ch_done) begin
            streaming <= 1'b0;
            if (idx_last) mode <= MODE_COMP;
          end
        end
        MODE_COMP: begin
          if (shot_done) mode <= MODE_RELOAD;
        end
        MODE_RELOAD: begin
          if (reload_done) begin
            mode      <= MODE_ACQ;
            streaming <= 1'b0;
          end
        end
        default: mode <= MODE_ACQ;
      endcase
    end
  end
endmodule

// File: rtl/beam_seq_top.sv
module beam_seq_top
  import beam_seq_pkg::*;
#(
  parameter int DIR_X    = 64,
  parameter int DIR_Y    = 64,
  parameter int NUM_CH   = 32,
  parameter int PAR_CH   = 4,
  parameter int NUM_BINS = 512,
  localparam int NUM_DIRS = DIR_X * DIR_Y,
  localparam int NUM_GRP  = NUM_CH / PAR_CH,
  localparam int DIR_W    = $clog2(NUM_DIRS),
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int BIN_W    = $clog2(NUM_BINS),
  localparam int PAR_SH   = $clog2(PAR_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             echo_ready,
  input  logic             reload_done,
  output logic [1:0]       mode,
  output logic             fe_en,
  output logic             rd_valid,
  output logic             acc_first,
  output logic [DIR_W-1:0] dir_idx,
  output logic [CH_W-1:0]  chan_idx,
  output logic [BIN_W-1:0] bin_addr,
  output logic             beam_done,
  output logic             shot_done
);
  seq_mode_e       mode_q;
  logic            ch_done, dir_inc, dir_clr;
  logic            bin_last, idx_last, dir_last;
  logic [CH_W-1:0] idx_cnt;
  logic [CH_W-1:0] idx_limit;

  // Channel index in acquisition, group base channel in compute.
  function automatic logic [CH_W-1:0] lane_base(input seq_mode_e m,
                                                input logic [CH_W-1:0] i);
    return (m == MODE_COMP) ? CH_W'(i << PAR_SH) : i;
  endfunction

  // Last index of the channel/group loop for the current mode.
  function automatic logic [CH_W-1:0] idx_top(input seq_mode_e m);
    return (m == MODE_COMP) ? CH_W'(NUM_GRP - 1) : CH_W'(NUM_CH - 1);
  endfunction

  assign idx_limit = idx_top(mode_q);

  beam_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .echo_ready (echo_ready),
    .reload_done(reload_done),
    .bin_last   (bin_last),
    .idx_last   (idx_last),
    .dir_last   (dir_last),
    .mode       (mode_q),
    .rd_valid   (rd_valid),
    .ch_done    (ch_done),
    .beam_done  (beam_done),
    .shot_done  (shot_done),
    .dir_inc    (dir_inc),
    .dir_clr    (dir_clr)
  );

  beam_seq_ctr #(.W(BIN_W)) u_bin (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (1'b0),
    .inc     (rd_valid),
    .last_val(BIN_W'(NUM_BINS - 1)),
    .cnt     (bin_addr),
    .at_last (bin_last)
  );

  beam_seq_ctr #(.W(CH_W)) u_idx (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (1'b0),
    .inc     (ch_done),
    .last_val(idx_limit),
    .cnt     (idx_cnt),
    .at_last (idx_last)
  );

  beam_seq_ctr #(.W(DIR_W)) u_dir (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (dir_clr),
    .inc     (dir_inc),
    .last_val(DIR_W'(NUM_DIRS - 1)),
    .cnt     (dir_idx),
    .at_last (dir_last)
  );

  assign mode      = mode_q;
  assign fe_en     = (mode_q == MODE_ACQ);
  assign chan_idx  = lane_base(mode_q, idx_cnt);
  assign acc_first = rd_valid && (idx_cnt == '0);
endmodule

// File: rtl/beam_seq_chk.sv
module beam_seq_chk #(
  parameter int DIR_W = 12,
  parameter int BIN_W = 9,
  parameter int NUM_BINS = 512
) (
  input logic             clk,
  input logic             rst_n,
  input logic             echo_ready,
  input logic             reload_done,
  input logic [1:0]       mode,
  input logic             rd_valid,
  input logic [DIR_W-1:0] dir_idx,
  input logic [BIN_W-1:0] bin_addr,
  input logic             beam_done,
  input logic             shot_done
);
  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !rd_valid && !echo_ready) |=> !rd_valid);

  p_bin_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && bin_addr != BIN_W'(NUM_BINS - 1)) |=>
      (rd_valid && bin_addr == $past(bin_addr) + BIN_W'(1)));

  p_acq_dir0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> (dir_idx == '0));

  p_comp_reads_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> rd_valid);

  p_beam_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    beam_done |=> !beam_done);

  p_dir_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !beam_done) |=> $stable(dir_idx));

  p_shot_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    shot_done |=> (mode == 2'd2 && !rd_valid));

  p_reload_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !reload_done) |=> (mode == 2'd2));

  p_reload_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && reload_done) |=> (mode == 2'd0 && dir_idx == '0 && !rd_valid));
endmodule

bind beam_seq_top beam_seq_chk #(
  .DIR_W(DIR_W), .BIN_W(BIN_W), .NUM_BINS(NUM_BINS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .echo_ready (echo_ready),
  .reload_done(reload_done),
  .mode       (mode),
  .rd_valid   (rd_valid),
  .dir_idx    (dir_idx),
  .bin_addr   (bin_addr),
  .beam_done  (beam_done),
  .shot_done  (shot_done)
);

// File: tb/sim_beam_seq_top.sv
module sim_beam_seq_top;
  localparam int DX = 2, DY = 2, NCH = 8, PAR = 4, NB = 8;
  localparam int ND = DX * DY, NG = NCH / PAR;
  localparam int DW = $clog2(ND), CW = $clog2(NCH), BW = $clog2(NB);
  localparam int SHOTS = 3;

  logic clk = 1'b0, rst_n = 1'b0, echo_ready = 1'b0, reload_done = 1'b0;
  logic [1:0] mode;
  logic fe_en, rd_valid, acc_first, beam_done, shot_done;
  logic [DW-1:0] dir_idx;
  logic [CW-1:0] chan_idx;
  logic [BW-1:0] bin_addr;

  int checks = 0, fails = 0;
  int m_mode = 0, m_dir = 0, m_idx = 0, m_bin = 0;
  bit m_run = 0;
  int shots_seen = 0, beams_seen = 0;

  always #2.5 clk = ~clk;

  beam_seq_top #(.DIR_X(DX), .DIR_Y(DY), .NUM_CH(NCH), .PAR_CH(PAR),
                 .NUM_BINS(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .echo_ready(echo_ready), .reload_done(reload_done),
    .mode(mode), .fe_en(fe_en), .rd_valid(rd_valid), .acc_first(acc_first),
    .dir_idx(dir_idx), .chan_idx(chan_idx), .bin_addr(bin_addr),
    .beam_done(beam_done), .shot_done(shot_done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_rd();
    return (m_mode == 0 && m_run) || m_mode == 1;
  endfunction
  function automatic int exp_chan();
    return (m_mode == 1) ? m_idx * PAR : m_idx;
  endfunction
  function automatic bit exp_beam();
    return exp_rd() && m_bin == NB - 1 && m_idx == ((m_mode == 1) ? NG - 1 : NCH - 1);
  endfunction

  task automatic compare(input string tag);
    chk(mode == 2'(m_mode), {tag, " R10 mode"}, mode, m_mode);
    chk(rd_valid == exp_rd(), {tag, " R2 rd_valid"}, rd_valid, exp_rd());
    chk(int'(dir_idx) == m_dir, {tag, " R6 dir_idx"}, dir_idx, m_dir);
    chk(int'(chan_idx) == exp_chan(), {tag, " R3/R5 chan_idx"}, chan_idx, exp_chan());
    chk(int'(bin_addr) == m_bin, {tag, " R5 bin_addr"}, bin_addr, m_bin);
    chk(fe_en == (m_mode == 0), {tag, " R4 fe_en"}, fe_en, m_mode == 0);
    chk(beam_done == exp_beam(), {tag, " R6 beam_done"}, beam_done, exp_beam());
    chk(shot_done == (exp_beam() && m_mode == 1 && m_dir == ND - 1),
        {tag, " R7 shot_done"}, shot_done, exp_beam() && m_mode == 1 && m_dir == ND - 1);
    chk(acc_first == (exp_rd() && m_idx == 0), {tag, " R9 acc_first"},
        acc_first, exp_rd() && m_idx == 0);
  endtask

  // Advance the model across one clock edge given the driven inputs (R2-R8, R10).
  task automatic step_model();
    case (m_mode)
      0: if (!m_run) begin
           if (echo_ready) m_run = 1;
         end else if (m_bin == NB - 1) begin
           m_bin = 0; m_run = 0;
           if (m_idx == NCH - 1) begin m_idx = 0; m_mode = 1; m_dir = 1; end
           else m_idx++;
         end else m_bin++;
      1: if (m_bin == NB - 1) begin
           m_bin = 0;
           if (m_idx == NG - 1) begin
             m_idx = 0;
             if (m_dir == ND - 1) m_mode = 2; else m_dir++;
           end else m_idx++;
         end else m_bin++;
      default: if (reload_done) begin m_mode = 0; m_dir = 0; m_run = 0; end
    endcase
  endtask

  initial begin
    int cyc = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    compare("reset R1");
    rst_n = 1'b1;
    // Directed: echo held low, no channel may start (R2).
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      compare("idle R2");
    end
    while (shots_seen < SHOTS && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      compare("run");
      if (beam_done) beams_seen++;
      if (shot_done) shots_seen++;
      echo_ready  = ($urandom % 3) != 0;      // also driven outside ACQ (R10)
      reload_done = ($urandom % 4) == 0;      // also pulsed outside RELOAD (R10)
      @(posedge clk);
      step_model();
    end
    chk(cyc < 20000, "watchdog R7", cyc, 20000);
    chk(beams_seen == SHOTS * ND, "beam count R6", beams_seen, SHOTS * ND);
    // Settle in reload, hold reload_done low (R8).
    echo_ready = 1'b1; reload_done = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      compare("hold R8");
      @(posedge clk);
      step_model();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule